// File: doc/BRIEF.md
# External Memory Bus Arbiter with Refresh Timer

This block decides which of five requesters owns a shared external memory bus: the CPU, a DMA controller, a multi-channel external DMA controller, an off-chip bus-release request, and an internal DRAM refresh timer. Each owner holds the bus until the current bus cycle reports completion. At that point, or whenever the bus has no owner, a new owner is chosen by fixed priority.

Transfer modes shape the hand-off. A DMA block or burst transfer may keep the bus across cycle boundaries. A multi-channel external DMA run keeps the bus while nobody else wants it. All other DMA ownership is given up after each cycle. Refresh requests come from a free-running counter that is compared against a programmable limit. A refresh is never granted twice in a row. The idle time that follows a refresh is marked as NOP cycles.

Top module: `ext_bus_arbiter`

## Requirements
- R1: While `rst_ni` is low, `gnt_o` is all zero, `refresh_cycle_o` and `nop_cycle_o` are low, and the refresh counter is zero.
- R2: `gnt_o` is one-hot or zero. It changes only on a clock edge where `cycle_done_i` is high or `gnt_o` was zero. Such an edge is called a decision edge.
- R3: At a decision edge the highest eligible requester wins. The order, from highest to lowest, is: refresh (`gnt_o[4]`), external release (`gnt_o[3]`), external DMA (`gnt_o[2]`), DMA (`gnt_o[1]`), CPU (`gnt_o[0]`). If no requester is eligible, `gnt_o` becomes zero.
- R4: The refresh counter counts up on each edge where `ref_en_i` and `dram_mode_i` are both high, and holds otherwise. On an enabled edge where the counter equals `ref_cmp_i`, the counter clears to zero and a refresh request becomes pending. The pending request stays set until refresh is granted.
- R5: `refresh_cycle_o` is high for exactly the first cycle of each refresh grant.
- R6: Refresh is not eligible at a decision edge where refresh is the current owner.
- R7: `nop_cycle_o` is high in every cycle with no owner that follows the end of a refresh grant, until the next grant.
- R8: The external release request is eligible only while `bus_rel_ni` is low, `rel_en_i` is high and `rel_sel_i` is high.
- R9: A DMA owner stays eligible at a decision edge only when `dma_req_i` and `dma_hold_i` are high and `cont_sel_i` is low. Otherwise DMA is excluded at that edge, and the bus passes to a lower requester or becomes ownerless.
- R10: An external DMA owner stays eligible only when at least two bits of `exd_req_i` are set and no other requester is eligible. Otherwise it is excluded at that edge. Any set bit makes a non-owning external DMA eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | CPU bus request |
| dma_req_i | input | 1 | DMA controller bus request |
| dma_hold_i | input | 1 | DMA is inside a block-mode block or a burst transfer |
| exd_req_i | input | NCH | External DMA per-channel requests |
| bus_rel_ni | input | 1 | Off-chip bus-release request, active low |
| rel_en_i | input | 1 | Bus-release enable |
| rel_sel_i | input | 1 | Interrupt-control select for the release pin |
| ref_en_i | input | 1 | Refresh enable |
| dram_mode_i | input | 1 | Refreshed area is configured as DRAM/SDRAM |
| ref_cmp_i | input | CNT_W | Refresh compare value |
| cont_sel_i | input | 1 | 1 forces DMA to give up the bus after every cycle |
| cycle_done_i | input | 1 | The current bus cycle completes on this edge |
| gnt_o | output | 5 | One-hot grant: 0 CPU, 1 DMA, 2 external DMA, 3 release, 4 refresh |
| refresh_cycle_o | output | 1 | Strobe on the first cycle of a refresh grant |
| nop_cycle_o | output | 1 | Bus idle following a refresh |

## Verification
The bench uses a compare value of zero with `cycle_done_i` held high. Under these conditions a refresh is pending again at once. A design that lets refresh follow itself would hold `gnt_o[4]` and never show the alternating refresh/NOP pattern.

The bench also toggles `dram_mode_i` and `ref_en_i` in the middle of a count. A counter that runs while disabled moves the refresh grant earlier.

DMA and external DMA runs end with `cycle_done_i`, under every combination of hold, continue-transfer and channel count. A design that ignores `cont_sel_i` keeps the bus where it should hand it to the CPU. A design that drops the channel-count rule leaves a gap where the bus should stay held.

The release pin, enable and select are each tried alone. This catches a gate that is missing one of its terms.

// File: rtl/ext_arb_pkg.sv
package ext_arb_pkg;
  localparam int NM    = 5;
  localparam int M_CPU = 0;
  localparam int M_DMA = 1;
  localparam int M_EXD = 2;
  localparam int M_REL = 3;
  localparam int M_REF = 4;
  typedef logic [NM-1:0] gnt_t;
endpackage

// File: rtl/ext_arb_refresh_timer.sv
module ext_arb_refresh_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_en_i,
  input  logic             dram_mode_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             take_i,
  output logic             pend_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic             run;
  logic             hit;

  assign run = ref_en_i && dram_mode_i;
  assign hit = run && (cnt_q == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (hit)      cnt_q <= '0;
      else if (run) cnt_q <= cnt_q + 1'b1;
      // a new match outranks a grant on the same edge
      if (hit)         pend_q <= 1'b1;
      else if (take_i) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  assert_cnt_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ref_en_i && dram_mode_i) |=> $stable(cnt_q));
  assert_cnt_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_en_i && dram_mode_i && cnt_q == cmp_i) |=> (cnt_q == '0 && pend_q));
  assert_pend_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !take_i) |=> pend_q);
endmodule

// File: rtl/ext_arb_release_gate.sv
module ext_arb_release_gate (
  input  logic bus_rel_ni,
  input  logic rel_en_i,
  input  logic rel_sel_i,
  output logic rel_req_o
);
  assign rel_req_o = !bus_rel_ni && rel_en_i && rel_sel_i;
endmodule

// File: rtl/ext_arb_core.sv
module ext_arb_core
  import ext_arb_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cpu_req_i,
  input  logic           dma_req_i,
  input  logic           dma_hold_i,
  input  logic           cont_sel_i,
  input  logic [NCH-1:0] exd_req_i,
  input  logic           rel_req_i,
  input  logic           ref_pend_i,
  input  logic           cycle_done_i,
  output gnt_t           gnt_o,
  output logic           ref_take_o,
  output logic           refresh_cycle_o,
  output logic           nop_cycle_o
);
  gnt_t gnt_q, gnt_d, req_vec, win;
  logic bnd, ref_elig, others_idle, exd_multi, dma_ok, exd_ok;
  logic stb_q, post_q, post_d;

  assign bnd         = cycle_done_i || (gnt_q == '0);
  assign ref_elig    = ref_pend_i && !gnt_q[M_REF];
  assign others_idle = !cpu_req_i && !dma_req_i && !rel_req_i && !ref_elig;
  assign exd_multi   = ($countones(exd_req_i) >= 2);
  assign dma_ok      = dma_req_i && (!gnt_q[M_DMA] || (dma_hold_i && !cont_sel_i));
  assign exd_ok      = (|exd_req_i) && (!gnt_q[M_EXD] || (exd_multi && others_idle));

  always_comb begin
    req_vec        = '0;
    req_vec[M_CPU] = cpu_req_i;
    req_vec[M_DMA] = dma_ok;
    req_vec[M_EXD] = exd_ok;
    req_vec[M_REL] = rel_req_i;
    req_vec[M_REF] = ref_elig;
  end

  // higher index overrides lower
  always_comb begin
    win = '0;
    for (int i = 0; i < NM; i++) begin
      if (req_vec[i]) begin
        win    = '0;
        win[i] = 1'b1;
      end
    end
  end

  assign gnt_d      = bnd ? win : gnt_q;
  assign ref_take_o = bnd && win[M_REF];

  always_comb begin
    if (gnt_d != '0)              post_d = 1'b0;
    else if (bnd && gnt_q[M_REF]) post_d = 1'b1;
    else                          post_d = post_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q  <= '0;
      stb_q  <= 1'b0;
      post_q <= 1'b0;
    end else begin
      gnt_q  <= gnt_d;
      stb_q  <= ref_take_o;
      post_q <= post_d;
    end
  end

  assign gnt_o           = gnt_q;
  assign refresh_cycle_o = stb_q;
  assign nop_cycle_o     = post_q && (gnt_q == '0);

  assert_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_q));
  assert_boundary_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cycle_done_i && gnt_q != '0) |=> $stable(gnt_q));
  assert_no_repeat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_q[M_REF] && cycle_done_i) |=> !gnt_q[M_REF]);
  assert_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_cycle_o |-> gnt_q[M_REF]);
  assert_strobe_once_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_cycle_o |=> !refresh_cycle_o);
  assert_nop_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nop_cycle_o |-> (gnt_q == '0));
  assert_dma_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_q[M_DMA] && cycle_done_i && !(dma_hold_i && !cont_sel_i)) |=> !gnt_q[M_DMA]);
  assert_exd_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_q[M_EXD] && cycle_done_i && (cpu_req_i || dma_req_i)) |=> !gnt_q[M_EXD]);
endmodule

// File: rtl/ext_bus_arbiter.sv
module ext_bus_arbiter
  import ext_arb_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_req_i,
  input  logic             dma_req_i,
  input  logic             dma_hold_i,
  input  logic [NCH-1:0]   exd_req_i,
  input  logic             bus_rel_ni,
  input  logic             rel_en_i,
  input  logic             rel_sel_i,
  input  logic             ref_en_i,
  input  logic             dram_mode_i,
  input  logic [CNT_W-1:0] ref_cmp_i,
  input  logic             cont_sel_i,
  input  logic             cycle_done_i,
  output logic [4:0]       gnt_o,
  output logic             refresh_cycle_o,
  output logic             nop_cycle_o
);
  logic rel_req, ref_pend, ref_take;
  gnt_t gnt;

  ext_arb_release_gate u_rel (
    .bus_rel_ni (bus_rel_ni),
    .rel_en_i   (rel_en_i),
    .rel_sel_i  (rel_sel_i),
    .rel_req_o  (rel_req)
  );

  ext_arb_refresh_timer #(.CNT_W(CNT_W)) u_ref (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ref_en_i    (ref_en_i),
    .dram_mode_i (dram_mode_i),
    .cmp_i       (ref_cmp_i),
    .take_i      (ref_take),
    .pend_o      (ref_pend)
  );

  ext_arb_core #(.NCH(NCH)) u_core (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .cpu_req_i       (cpu_req_i),
    .dma_req_i       (dma_req_i),
    .dma_hold_i      (dma_hold_i),
    .cont_sel_i      (cont_sel_i),
    .exd_req_i       (exd_req_i),
    .rel_req_i       (rel_req),
    .ref_pend_i      (ref_pend),
    .cycle_done_i    (cycle_done_i),
    .gnt_o           (gnt),
    .ref_take_o      (ref_take),
    .refresh_cycle_o (refresh_cycle_o),
    .nop_cycle_o     (nop_cycle_o)
  );

  assign gnt_o = gnt;

  assert_rel_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gnt[M_REL]) |-> $past(!bus_rel_ni && rel_en_i && rel_sel_i));
endmodule

// File: tb/ext_bus_arbiter_test.sv
module ext_bus_arbiter_test;
  localparam int NCH   = 4;
  localparam int CNT_W = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cpu_req = 0, dma_req = 0, dma_hold = 0, cont_sel = 0;
  logic [NCH-1:0] exd_req = '0;
  logic bus_rel_n = 1, rel_en = 0, rel_sel = 0;
  logic ref_en = 0, dram_mode = 0, cycle_done = 0;
  logic [CNT_W-1:0] ref_cmp = '0;
  logic [4:0] gnt;
  logic ref_stb, nop;

  int checks = 0, fails = 0, cyc = 0;

  // bench model state
  logic [4:0] m_gnt = '0;
  logic [CNT_W-1:0] m_cnt = '0;
  logic m_pend = 0, m_stb = 0, m_post = 0;

  always #4 clk = ~clk;

  ext_bus_arbiter #(.NCH(NCH), .CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_req_i(cpu_req), .dma_req_i(dma_req),
    .dma_hold_i(dma_hold), .exd_req_i(exd_req), .bus_rel_ni(bus_rel_n),
    .rel_en_i(rel_en), .rel_sel_i(rel_sel), .ref_en_i(ref_en),
    .dram_mode_i(dram_mode), .ref_cmp_i(ref_cmp), .cont_sel_i(cont_sel),
    .cycle_done_i(cycle_done), .gnt_o(gnt), .refresh_cycle_o(ref_stb),
    .nop_cycle_o(nop)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL R2 watchdog expired: act=%0d exp=<150000", cyc);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // next-state model built from the requirements
  function automatic logic [4:0] pick(input logic [4:0] cur);
    logic rel, refel, idle, dma_ok, exd_ok;
    logic [4:0] w;
    rel    = !bus_rel_n && rel_en && rel_sel;
    refel  = m_pend && !cur[4];
    idle   = !cpu_req && !dma_req && !rel && !refel;
    dma_ok = dma_req && (!cur[1] || (dma_hold && !cont_sel));
    exd_ok = (exd_req != 0) && (!cur[2] || ($countones(exd_req) >= 2 && idle));
    if (refel)       w = 5'b10000;
    else if (rel)    w = 5'b01000;
    else if (exd_ok) w = 5'b00100;
    else if (dma_ok) w = 5'b00010;
    else if (cpu_req) w = 5'b00001;
    else             w = 5'b00000;
    return w;
  endfunction

  task automatic model_step();
    logic bnd, take, hit, run;
    logic [4:0] ng;
    bnd  = cycle_done || (m_gnt == 0);
    ng   = bnd ? pick(m_gnt) : m_gnt;
    take = bnd && ng[4];
    run  = ref_en && dram_mode;
    hit  = run && (m_cnt == ref_cmp);
    if (ng != 0) m_post = 0;
    else if (bnd && m_gnt[4]) m_post = 1;
    m_stb = take;
    if (hit) begin m_cnt = '0; m_pend = 1; end
    else begin
      if (run) m_cnt = m_cnt + 1'b1;
      if (take) m_pend = 0;
    end
    m_gnt = ng;
  endtask

  task automatic cyc_check(input string tag);
    logic [4:0] prev;
    logic done_used;
    prev = m_gnt;
    done_used = cycle_done;
    @(negedge clk);
    model_step();
    check(gnt == m_gnt, tag, gnt, m_gnt);
    check(ref_stb == m_stb, "R5", ref_stb, m_stb);
    check(nop == (m_post && m_gnt == 0), "R7", nop, m_post);
    check($onehot0(gnt), "R2", gnt, 0);
    if (!done_used && prev != 0) check(gnt == prev, "R2", gnt, prev);
  endtask

  task automatic idle_inputs();
    cpu_req = 0; dma_req = 0; dma_hold = 0; cont_sel = 0; exd_req = '0;
    bus_rel_n = 1; rel_en = 0; rel_sel = 0; ref_en = 0; dram_mode = 0;
  endtask

  initial begin
    void'($urandom(32'd20241));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(gnt == 0 && !ref_stb && !nop, "R1", {gnt, ref_stb, nop}, 0);
    rst_ni = 1'b1;

    // R6/R7: compare value zero keeps refresh pending at once
    ref_en = 1; dram_mode = 1; ref_cmp = '0; cycle_done = 1;
    for (int i = 0; i < 16; i++) cyc_check("R6");

    // R4: counter runs only with enable and DRAM mode
    ref_cmp = 10'd5; cpu_req = 1;
    for (int i = 0; i < 400; i++) begin
      cycle_done = ($urandom % 3) == 0;
      ref_en = ($urandom % 8) != 0;
      dram_mode = ($urandom % 5) != 0;
      cpu_req = ($urandom % 4) != 0;
      cyc_check("R4");
    end
    idle_inputs();
    cycle_done = 1;
    cyc_check("R4");

    // R8: each term of the release gate alone and together
    for (int i = 0; i < 400; i++) begin
      bus_rel_n = $urandom % 2; rel_en = $urandom % 2; rel_sel = $urandom % 2;
      cpu_req = $urandom % 2; cycle_done = ($urandom % 2) == 0;
      cyc_check("R8");
    end
    idle_inputs();

    // R9: DMA hold versus continue-transfer
    for (int i = 0; i < 500; i++) begin
      dma_req = ($urandom % 5) != 0; dma_hold = $urandom % 2;
      cont_sel = ($urandom % 3) == 0; cpu_req = $urandom % 2;
      exd_req = (($urandom % 6) == 0) ? 4'b0001 : 4'b0000;
      cycle_done = ($urandom % 2) == 0;
      cyc_check("R9");
    end
    idle_inputs();

    // R10: external DMA channel count
    for (int i = 0; i < 500; i++) begin
      exd_req = $urandom % 16;
      cpu_req = ($urandom % 4) == 0; dma_req = ($urandom % 5) == 0;
      cycle_done = ($urandom % 2) == 0;
      cyc_check("R10");
    end

    // R3: everything at once
    ref_cmp = 10'd7;
    for (int i = 0; i < 2000; i++) begin
      cpu_req = $urandom % 2; dma_req = $urandom % 2; dma_hold = $urandom % 2;
      cont_sel = $urandom % 2; exd_req = $urandom % 16;
      bus_rel_n = ($urandom % 4) != 0; rel_en = $urandom % 2; rel_sel = $urandom % 2;
      ref_en = ($urandom % 6) != 0; dram_mode = ($urandom % 6) != 0;
      cycle_done = $urandom % 2;
      cyc_check("R3");
    end

    summary();
  end
endmodule